// File: doc/BRIEF.md
# Single-Character Command Decoder

This block sits between a host byte link and the control side of a logic capture engine. Command bytes arrive under a valid/ready handshake. Each byte is a single printable ASCII character. Recognised characters become one-cycle control pulses toward the capture engine: start, stop, clear, raw dump, text dump and identify. Two characters also produce a reply on an outgoing byte stream, which uses its own valid/ready handshake.

A status query returns one ASCII letter. The letter is picked by priority from the engine's running, stopped and full flags, as they stand when the query byte is accepted. An identify request returns a fixed seven-byte string that ends in a newline. Characters the decoder does not know are consumed and dropped. While any reply byte is still waiting, the input side is closed, so commands and replies never overlap.

Top module: `cmd_decoder`

## Requirements
- R1: A byte is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. Accepting 'g' (0x67) raises `go_pulse` for exactly the one cycle after the accepting edge.
- R2: Accepting 's' (0x73) raises `halt_pulse` for exactly the one cycle after the accepting edge.
- R3: Accepting 'r' (0x72) raises `clear_pulse` for exactly the one cycle after the accepting edge.
- R4: Accepting 'd' (0x64) raises `dump_raw_pulse` for one cycle. Accepting 'D' (0x44) raises `dump_text_pulse` for one cycle.
- R5: Accepting 'i' (0x69) raises `ident_pulse` for one cycle. It also sends the bytes 0x4C 0x4F 0x47 0x49 0x43 0x38 0x0A ("LOGIC8" and a newline) in that order on the reply stream.
- R6: Accepting 'S' (0x53) sends exactly one reply byte and raises no control pulse.
- R7: The status letter uses the flags sampled at the accepting edge, with full taking priority. It is 'f' (0x66) when `cap_full` is high. Otherwise it is 'r' (0x72) when `cap_running` is high and `cap_stopped` is low. In every other case it is 's' (0x73).
- R8: Any other byte value is consumed. It raises no pulse and produces no reply.
- R9: `cmd_ready` is low whenever `rsp_valid` is high, so no command is accepted while a reply byte is pending.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_byte` holds its value.
- R11: Under reset and right after it, `rsp_valid` and all pulses are low and `cmd_ready` is high.
- R12: At most one control pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_byte | input | 8 | Incoming command character |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Decoder can take a command |
| rsp_byte | output | 8 | Outgoing reply character |
| rsp_valid | output | 1 | Reply byte present |
| rsp_ready | input | 1 | Receiver takes the reply byte |
| cap_running | input | 1 | Capture engine is sampling |
| cap_stopped | input | 1 | Capture engine is idle |
| cap_full | input | 1 | Capture memory is full |
| go_pulse | output | 1 | Start sampling |
| halt_pulse | output | 1 | Stop sampling |
| clear_pulse | output | 1 | Reset the analyzer |
| dump_raw_pulse | output | 1 | Begin binary dump |
| dump_text_pulse | output | 1 | Begin ASCII dump |
| ident_pulse | output | 1 | Identify requested |

## Verification
A wrong decode shows up in the cycle right after the accepting edge. It appears as a missing, extra or misrouted pulse, or as a reply byte that should not exist. A broken identify index shows as a wrong, skipped or repeated byte somewhere in the seven-byte reply, and it is caught when that byte transfers. A stuck busy condition shows as `cmd_ready` staying low, which stalls the next command. A busy condition that clears too early lets a command in while a reply is still pending. The bench stalls the reply side at random to expose both cases.

// File: rtl/cmd_decoder.sv
module cmd_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  output logic [7:0] rsp_byte,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  input  logic       cap_running,
  input  logic       cap_stopped,
  input  logic       cap_full,
  output logic       go_pulse,
  output logic       halt_pulse,
  output logic       clear_pulse,
  output logic       dump_raw_pulse,
  output logic       dump_text_pulse,
  output logic       ident_pulse
);

  localparam logic [7:0] CH_GO     = 8'h67;
  localparam logic [7:0] CH_HALT   = 8'h73;
  localparam logic [7:0] CH_CLEAR  = 8'h72;
  localparam logic [7:0] CH_RAW    = 8'h64;
  localparam logic [7:0] CH_TEXT   = 8'h44;
  localparam logic [7:0] CH_IDENT  = 8'h69;
  localparam logic [7:0] CH_STATUS = 8'h53;
  localparam int         ID_LEN    = 7;
  localparam int         IDX_W     = $clog2(ID_LEN + 1);

  function automatic logic [7:0] id_char(input logic [IDX_W-1:0] k);
    case (k)
      0: id_char = 8'h4C;
      1: id_char = 8'h4F;
      2: id_char = 8'h47;
      3: id_char = 8'h49;
      4: id_char = 8'h43;
      5: id_char = 8'h38;
      default: id_char = 8'h0A;
    endcase
  endfunction

  logic             accept;
  logic [7:0]       status_char;
  logic [IDX_W-1:0] id_idx;
  logic             id_active;

  assign cmd_ready   = ~rsp_valid;
  assign accept      = cmd_valid & cmd_ready;
  assign status_char = cap_full                    ? 8'h66 :
                       (cap_running & ~cap_stopped) ? 8'h72 : 8'h73;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_pulse        <= 1'b0;
      halt_pulse      <= 1'b0;
      clear_pulse     <= 1'b0;
      dump_raw_pulse  <= 1'b0;
      dump_text_pulse <= 1'b0;
      ident_pulse     <= 1'b0;
    end else begin
      go_pulse        <= accept && cmd_byte == CH_GO;
      halt_pulse      <= accept && cmd_byte == CH_HALT;
      clear_pulse     <= accept && cmd_byte == CH_CLEAR;
      dump_raw_pulse  <= accept && cmd_byte == CH_RAW;
      dump_text_pulse <= accept && cmd_byte == CH_TEXT;
      ident_pulse     <= accept && cmd_byte == CH_IDENT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_byte  <= 8'h00;
      id_idx    <= '0;
      id_active <= 1'b0;
    end else if (accept && cmd_byte == CH_STATUS) begin
      rsp_valid <= 1'b1;
      rsp_byte  <= status_char;
      id_active <= 1'b0;
    end else if (accept && cmd_byte == CH_IDENT) begin
      rsp_valid <= 1'b1;
      rsp_byte  <= id_char('0);
      id_idx    <= IDX_W'(1);
      id_active <= 1'b1;
    end else if (rsp_valid && rsp_ready) begin
      if (id_active && id_idx != IDX_W'(ID_LEN)) begin
        rsp_byte <= id_char(id_idx);
        id_idx   <= id_idx + 1'b1;
      end else begin
        rsp_valid <= 1'b0;
        id_active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cmd_decoder_chk.sv
module cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cmd_byte,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] rsp_byte,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic       cap_running,
  input logic       cap_stopped,
  input logic       cap_full,
  input logic       go_pulse,
  input logic       halt_pulse,
  input logic       clear_pulse,
  input logic       dump_raw_pulse,
  input logic       dump_text_pulse,
  input logic       ident_pulse
);
  logic take;
  assign take = cmd_valid & cmd_ready;

  assert_go_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse |-> $past(take && cmd_byte == 8'h67));
  assert_halt_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |-> $past(take && cmd_byte == 8'h73));
  assert_clear_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |-> $past(take && cmd_byte == 8'h72));
  assert_dump_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_raw_pulse |-> $past(take && cmd_byte == 8'h64)) and
    (dump_text_pulse |-> $past(take && cmd_byte == 8'h44)));
  assert_ident_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_byte == 8'h69 |=> ident_pulse && rsp_valid && rsp_byte == 8'h4C);
  assert_status_letter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_byte == 8'h53 |=> rsp_valid &&
      rsp_byte == ($past(cap_full) ? 8'h66 :
                   ($past(cap_running) && !$past(cap_stopped)) ? 8'h72 : 8'h73));
  assert_unknown_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && !(cmd_byte inside {8'h67, 8'h73, 8'h72, 8'h64, 8'h44, 8'h69, 8'h53})
      |=> !rsp_valid && !go_pulse && !halt_pulse && !clear_pulse &&
          !dump_raw_pulse && !dump_text_pulse && !ident_pulse);
  assert_busy_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_byte));
  assert_pulse_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_pulse, halt_pulse, clear_pulse, dump_raw_pulse, dump_text_pulse, ident_pulse}));
endmodule

bind cmd_decoder cmd_decoder_chk chk_i (.*);

// File: tb/cmd_decoder_tb_top.sv
module cmd_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] rsp_byte;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic       cap_running = 1'b0, cap_stopped = 1'b0, cap_full = 1'b0;
  logic       go_pulse, halt_pulse, clear_pulse, dump_raw_pulse, dump_text_pulse, ident_pulse;

  int checks = 0;
  int errors = 0;
  bit stall_all = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic       prev_hold = 1'b0;
  logic [7:0] prev_byte = 8'h00;

  always #4 clk = ~clk;

  cmd_decoder dut_i (.*);

  function automatic logic [5:0] pulse_vec();
    return {go_pulse, halt_pulse, clear_pulse, dump_raw_pulse, dump_text_pulse, ident_pulse};
  endfunction

  function automatic logic [5:0] exp_pulses(input logic [7:0] c);
    case (c)
      8'h67: return 6'b100000;
      8'h73: return 6'b010000;
      8'h72: return 6'b001000;
      8'h64: return 6'b000100;
      8'h44: return 6'b000010;
      8'h69: return 6'b000001;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] c);
    case (c)
      8'h67: return "R1";
      8'h73: return "R2";
      8'h72: return "R3";
      8'h64, 8'h44: return "R4";
      8'h69: return "R5";
      8'h53: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [7:0] exp_status(input logic f, input logic r, input logic s);
    if (f) return 8'h66;
    if (r && !s) return 8'h72;
    return 8'h73;
  endfunction

  function automatic logic [7:0] exp_id(input int k);
    logic [7:0] t [7] = '{8'h4C, 8'h4F, 8'h47, 8'h49, 8'h43, 8'h38, 8'h0A};
    return t[k];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    rsp_ready = stall_all ? 1'b0 : (($urandom % 4) != 0);
    #1;
    if (rst_n) begin
      if (prev_hold)
        chk(rsp_valid && rsp_byte == prev_byte, "R10", {23'b0, rsp_valid, rsp_byte}, {24'b1, prev_byte});
      prev_hold = rsp_valid && !rsp_ready;
      prev_byte = rsp_byte;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R8", rsp_byte, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rsp_byte == e, "R5/R7 reply byte", rsp_byte, e);
        end
      end
    end
  end

  task automatic send(input logic [7:0] c, input bit rnd_flags, input logic [2:0] flags);
    logic [5:0] ev;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    if (rnd_flags) {cap_full, cap_running, cap_stopped} = 3'($urandom);
    else {cap_full, cap_running, cap_stopped} = flags;
    cmd_byte = c;
    cmd_valid = 1'b1;
    ev = exp_pulses(c);
    if (c == 8'h53) exp_q.push_back(exp_status(cap_full, cap_running, cap_stopped));
    if (c == 8'h69) for (int k = 0; k < 7; k++) exp_q.push_back(exp_id(k));
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_byte = 8'($urandom);
    chk(pulse_vec() == ev, req_of(c), pulse_vec(), ev);
    if (c == 8'h53 || c == 8'h69) chk(!cmd_ready && rsp_valid, "R9", cmd_ready, 0);
    else if (ev == 0) chk(!rsp_valid, "R8", rsp_valid, 0);
    @(negedge clk);
    chk(pulse_vec() == 6'b0, {req_of(c), " single cycle"}, pulse_vec(), 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [12] = '{8'h67, 8'h73, 8'h72, 8'h64, 8'h44, 8'h69, 8'h53,
                              8'h47, 8'h78, 8'h00, 8'hFF, 8'h49};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!rsp_valid && cmd_ready && pulse_vec() == 0, "R11", {rsp_valid, cmd_ready, pulse_vec()}, 8'b01000000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && cmd_ready && pulse_vec() == 0, "R11", {rsp_valid, cmd_ready, pulse_vec()}, 8'b01000000);

    send(8'h67, 0, 3'b000);
    send(8'h73, 0, 3'b000);
    send(8'h72, 0, 3'b000);
    send(8'h64, 0, 3'b000);
    send(8'h44, 0, 3'b000);
    for (int f = 0; f < 8; f++) begin
      send(8'h53, 0, 3'(f));
      drain();
    end
    send(8'h69, 0, 3'b000);
    drain();
    send(8'h47, 0, 3'b000);
    send(8'h00, 0, 3'b000);
    send(8'hFF, 0, 3'b000);
    chk(!rsp_valid, "R8", rsp_valid, 0);

    stall_all = 1'b1;
    send(8'h69, 0, 3'b000);
    @(negedge clk);
    cmd_byte = 8'h67;
    cmd_valid = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk(!go_pulse && !cmd_ready, "R9", {go_pulse, cmd_ready}, 0);
    end
    stall_all = 1'b0;
    while (!cmd_ready) begin
      @(negedge clk);
      chk(!go_pulse, "R9", go_pulse, 0);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(go_pulse, "R1 after reply", go_pulse, 1);
    @(negedge clk);
    chk(!go_pulse, "R1 single cycle", go_pulse, 0);

    for (int n = 0; n < 400; n++) begin
      send(pool[$urandom % 12], 1, 3'b000);
      if (($urandom % 3) == 0) drain();
    end
    drain();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && !rsp_valid, "R6", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule